// File: doc/BRIEF.md
# Message Buffer Flag and Interrupt Control

This block keeps the control and status flags of a single message buffer in a CAN controller, together with the buffer's type field and its interrupt enable. It sits between two agents. One is the CPU, which configures the buffer and sets or clears flags. The other is the protocol engine, which reports that a transmission has completed or that a frame has been stored. From those reports it raises a transmit-class or receive-class interrupt pulse and updates the flags.

A ready flag hands the buffer to the protocol engine. While the flag is high, the write-permit output is low, so the buffer's data and identifier storage refuses CPU writes. The type and interrupt-enable configuration is frozen at the same time. The flag register itself stays writable through per-bit set and clear masks. Engine reports that arrive while the buffer is not ready are ignored. Reports that do not match the buffer's type are ignored as well.

Top module: `msgbuf_ctl`

## Requirements
- R1: After a synchronous active-high reset, all four flags are 0. The type field and the interrupt enable are also 0. Both interrupt outputs are 0 and `bufWrPermit` is 1.
- R2: `bufWrPermit` is the inverse of the ready flag. A config write (`cpuCfgWr`) loads `cpuCfgData[2:0]` into the type field and `cpuCfgData[3]` into the interrupt enable. The load happens only while ready is 0; while ready is 1 the write is ignored.
- R3: Flag mask bit positions are 0 = ready, 1 = transmit request, 2 = data-new, 3 = overwrite. On `cpuFlagWr`, ready and transmit request follow the set and clear masks, and a clear wins over a set. This holds whatever the value of ready.
- R4: Data-new and overwrite cannot be set by the CPU, because set-mask bits 2 and 3 are ignored. They can only be cleared by the CPU.
- R5: An accepted transmit-done event clears the transmit-request flag on the next clock edge. If the CPU sets that flag in the same cycle, the flag ends at 1.
- R6: `irqTx` is a one-cycle pulse, coincident with the transmit-done event, when ready is 1, the type is 0 and the interrupt enable is 1.
- R7: `irqRx` pulses coincident with a data-stored event into a buffer of type 1 to 5. It also pulses coincident with a remote-stored event into a buffer of type 0. In both cases ready and the interrupt enable must be 1.
- R8: Each accepted store event sets data-new. A CPU clear of data-new in the same cycle loses to the store.
- R9: An accepted store while data-new is already 1 sets overwrite. Overwrite stays 1 until the CPU clears it, and a store in the same cycle wins over that clear.
- R10: Events that arrive while ready is 0, or that do not match the buffer type, change no flag and raise no interrupt. Such mismatched events include transmit-done or remote-stored on type 1 to 7 and data-stored on type 0, 6 or 7.
- R11: With the interrupt enable at 0, accepted events update the flags exactly as usual but raise no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpuCfgWr | input | 1 | CPU write strobe for type and interrupt enable |
| cpuCfgData | input | 4 | Config data: [2:0] type, [3] interrupt enable |
| cpuFlagWr | input | 1 | CPU flag write strobe |
| cpuFlagSet | input | 4 | Per-flag set mask |
| cpuFlagClr | input | 4 | Per-flag clear mask |
| evTxDone | input | 1 | Engine: frame sent from this buffer |
| evDataStored | input | 1 | Engine: valid data frame stored |
| evRemoteStored | input | 1 | Engine: valid remote frame stored |
| flagReady | output | 1 | Buffer owned by the engine |
| flagTxReq | output | 1 | Transmission pending or in progress |
| flagDataNew | output | 1 | Frame stored since last clear |
| flagOverwrite | output | 1 | Frame stored over unread data |
| bufType | output | 3 | Buffer type field |
| intEnable | output | 1 | Interrupt enable |
| irqTx | output | 1 | Transmit-class interrupt pulse |
| irqRx | output | 1 | Receive-class interrupt pulse |
| bufWrPermit | output | 1 | CPU may write data and identifier storage |

## Verification
Two collisions matter most. The first is a hardware store event in the same cycle as a CPU clear of data-new or overwrite. The second is a transmit-done in the same cycle as a CPU set of the transmit request. The bench forces both in directed cycles, and after the edge it expects the store and the CPU set to have won. A long stretch of random cycles then lets events and flag writes coincide freely. In every cycle the flags and pulses are compared with a behavioural model that applies the stated priorities.

// File: rtl/msgbuf_ctl_pkg.sv
package msgbuf_ctl_pkg;

  localparam int FLAG_CNT = 4;
  localparam int FL_READY = 0;
  localparam int FL_TXREQ = 1;
  localparam int FL_DNEW  = 2;
  localparam int FL_OWR   = 3;

  // flags the CPU may set; the others are clear-only
  localparam logic [FLAG_CNT-1:0] SW_SET_MASK = 4'b0011;

  typedef struct packed {
    logic setDn;
    logic setOw;
    logic clrTrq;
    logic loadCfg;
  } mbStrobe_t;

endpackage

// File: rtl/msgbuf_ctl_decide.sv
module msgbuf_ctl_decide
  import msgbuf_ctl_pkg::*;
#(
  parameter int TYPE_W     = 3,
  parameter int TX_TYPE    = 0,
  parameter int RX_TYPE_LO = 1,
  parameter int RX_TYPE_HI = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuCfgWr,
  input  logic              ready,
  input  logic              dataNew,
  input  logic [TYPE_W-1:0] bufType,
  input  logic              intEn,
  input  logic              evTxDone,
  input  logic              evDataStored,
  input  logic              evRemoteStored,
  output mbStrobe_t         strobe,
  output logic              irqTx,
  output logic              irqRx
);

  logic isTxBuf, isRxBuf;
  logic txAccept, dataAccept, remoteAccept, storeAccept;

  always_comb begin
    isTxBuf = (bufType == TYPE_W'(TX_TYPE));
    isRxBuf = (bufType >= TYPE_W'(RX_TYPE_LO)) && (bufType <= TYPE_W'(RX_TYPE_HI));
  end

  always_comb begin
    txAccept     = ready && evTxDone && isTxBuf;
    dataAccept   = ready && evDataStored && isRxBuf;
    remoteAccept = ready && evRemoteStored && isTxBuf;
    storeAccept  = dataAccept || remoteAccept;
  end

  always_comb begin
    strobe.setDn   = storeAccept;
    strobe.setOw   = storeAccept && dataNew;
    strobe.clrTrq  = txAccept;
    strobe.loadCfg = cpuCfgWr && !ready;
  end

  assign irqTx = txAccept && intEn;
  assign irqRx = storeAccept && intEn;

  // R10
  idleNoIrq_chk: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (!irqTx && !irqRx));

  // R11
  maskNoIrq_chk: assert property (@(posedge clk) disable iff (rst)
    !intEn |-> (!irqTx && !irqRx));

  // R6
  txIrqClass_chk: assert property (@(posedge clk) disable iff (rst)
    irqTx |-> evTxDone);

endmodule

// File: rtl/msgbuf_ctl_flags.sv
module msgbuf_ctl_flags
  import msgbuf_ctl_pkg::*;
#(
  parameter int TYPE_W = 3,
  localparam int CFG_W = TYPE_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  mbStrobe_t           strobe,
  input  logic                cpuFlagWr,
  input  logic [FLAG_CNT-1:0] cpuFlagSet,
  input  logic [FLAG_CNT-1:0] cpuFlagClr,
  input  logic [CFG_W-1:0]    cpuCfgData,
  output logic [FLAG_CNT-1:0] flags,
  output logic [TYPE_W-1:0]   bufType,
  output logic                intEn
);

  logic [FLAG_CNT-1:0] hwSet, hwClr, swSet, swClr;
  logic [CFG_W-1:0]    cfgReg;

  always_comb begin
    hwSet = '0;
    hwClr = '0;
    hwSet[FL_DNEW]  = strobe.setDn;
    hwSet[FL_OWR]   = strobe.setOw;
    hwClr[FL_TXREQ] = strobe.clrTrq;
    swSet = cpuFlagWr ? (cpuFlagSet & SW_SET_MASK) : '0;
    swClr = cpuFlagWr ? cpuFlagClr : '0;
  end

  // priority per bit: hardware set, CPU clear, CPU set, hardware clear
  for (genvar i = 0; i < FLAG_CNT; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           flags[i] <= 1'b0;
      else if (hwSet[i]) flags[i] <= 1'b1;
      else if (swClr[i]) flags[i] <= 1'b0;
      else if (swSet[i]) flags[i] <= 1'b1;
      else if (hwClr[i]) flags[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 cfgReg <= '0;
    else if (strobe.loadCfg) cfgReg <= cpuCfgData;
  end

  assign bufType = cfgReg[TYPE_W-1:0];
  assign intEn   = cfgReg[TYPE_W];

  // R4
  dnOnlyByHw_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[FL_DNEW]) |-> $past(strobe.setDn));

  // R8
  dnHwWins_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.setDn |=> flags[FL_DNEW]);

  // R9
  owSticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flags[FL_OWR] && !(cpuFlagWr && cpuFlagClr[FL_OWR])) |=> flags[FL_OWR]);

  // R5
  trqCleared_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.clrTrq && !(cpuFlagWr && cpuFlagSet[FL_TXREQ])) |=> !flags[FL_TXREQ]);

  // R2
  cfgFrozen_chk: assert property (@(posedge clk) disable iff (rst)
    $past(flags[FL_READY]) |-> $stable(cfgReg));

endmodule

// File: rtl/msgbuf_ctl.sv
module msgbuf_ctl
  import msgbuf_ctl_pkg::*;
#(
  parameter int TYPE_W     = 3,
  parameter int TX_TYPE    = 0,
  parameter int RX_TYPE_LO = 1,
  parameter int RX_TYPE_HI = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuCfgWr,
  input  logic [TYPE_W:0]   cpuCfgData,
  input  logic              cpuFlagWr,
  input  logic [3:0]        cpuFlagSet,
  input  logic [3:0]        cpuFlagClr,
  input  logic              evTxDone,
  input  logic              evDataStored,
  input  logic              evRemoteStored,
  output logic              flagReady,
  output logic              flagTxReq,
  output logic              flagDataNew,
  output logic              flagOverwrite,
  output logic [TYPE_W-1:0] bufType,
  output logic              intEnable,
  output logic              irqTx,
  output logic              irqRx,
  output logic              bufWrPermit
);

  mbStrobe_t           strobe;
  logic [FLAG_CNT-1:0] flags;

  msgbuf_ctl_decide #(
    .TYPE_W(TYPE_W), .TX_TYPE(TX_TYPE),
    .RX_TYPE_LO(RX_TYPE_LO), .RX_TYPE_HI(RX_TYPE_HI)
  ) u_decide (
    .clk(clk), .rst(rst),
    .cpuCfgWr(cpuCfgWr),
    .ready(flags[FL_READY]),
    .dataNew(flags[FL_DNEW]),
    .bufType(bufType),
    .intEn(intEnable),
    .evTxDone(evTxDone),
    .evDataStored(evDataStored),
    .evRemoteStored(evRemoteStored),
    .strobe(strobe),
    .irqTx(irqTx),
    .irqRx(irqRx)
  );

  msgbuf_ctl_flags #(.TYPE_W(TYPE_W)) u_flags (
    .clk(clk), .rst(rst),
    .strobe(strobe),
    .cpuFlagWr(cpuFlagWr),
    .cpuFlagSet(cpuFlagSet),
    .cpuFlagClr(cpuFlagClr),
    .cpuCfgData(cpuCfgData),
    .flags(flags),
    .bufType(bufType),
    .intEn(intEnable)
  );

  assign flagReady     = flags[FL_READY];
  assign flagTxReq     = flags[FL_TXREQ];
  assign flagDataNew   = flags[FL_DNEW];
  assign flagOverwrite = flags[FL_OWR];
  assign bufWrPermit   = !flags[FL_READY];

  // R2
  permitOwnership_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flagReady) |-> !bufWrPermit);

endmodule

// File: tb/msgbuf_ctl_test.sv
module msgbuf_ctl_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpuCfgWr = 1'b0;
  logic [3:0] cpuCfgData = '0;
  logic       cpuFlagWr = 1'b0;
  logic [3:0] cpuFlagSet = '0;
  logic [3:0] cpuFlagClr = '0;
  logic       evTxDone = 1'b0, evDataStored = 1'b0, evRemoteStored = 1'b0;
  logic       flagReady, flagTxReq, flagDataNew, flagOverwrite;
  logic [2:0] bufType;
  logic       intEnable, irqTx, irqRx, bufWrPermit;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural model state
  bit mReady, mTrq, mDn, mOw, mIe;
  int mType;

  always #5 clk = ~clk;

  msgbuf_ctl uut (
    .clk(clk), .rst(rst),
    .cpuCfgWr(cpuCfgWr), .cpuCfgData(cpuCfgData),
    .cpuFlagWr(cpuFlagWr), .cpuFlagSet(cpuFlagSet), .cpuFlagClr(cpuFlagClr),
    .evTxDone(evTxDone), .evDataStored(evDataStored), .evRemoteStored(evRemoteStored),
    .flagReady(flagReady), .flagTxReq(flagTxReq), .flagDataNew(flagDataNew),
    .flagOverwrite(flagOverwrite), .bufType(bufType), .intEnable(intEnable),
    .irqTx(irqTx), .irqRx(irqRx), .bufWrPermit(bufWrPermit)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit txOk();
    return mReady && evTxDone && (mType == 0);
  endfunction

  function automatic bit storeOk();
    return mReady && ((evDataStored && mType >= 1 && mType <= 5) ||
                      (evRemoteStored && mType == 0));
  endfunction

  task automatic startCyc();
    @(negedge clk);
    cpuCfgWr = 0; cpuCfgData = '0; cpuFlagWr = 0; cpuFlagSet = '0; cpuFlagClr = '0;
    evTxDone = 0; evDataStored = 0; evRemoteStored = 0;
  endtask

  task automatic endCyc();
    bit st, tx, nDn, nOw, nTrq, nReady;
    #1;
    chk("R3", "ready", flagReady, mReady);
    chk("R5", "txReq", flagTxReq, mTrq);
    chk("R8", "dataNew", flagDataNew, mDn);
    chk("R9", "overwrite", flagOverwrite, mOw);
    chk("R2", "type", bufType, mType);
    chk("R2", "intEn", intEnable, mIe);
    chk("R2", "permit", bufWrPermit, !mReady);
    chk("R6", "irqTx", irqTx, !rst && txOk() && mIe);
    chk("R7", "irqRx", irqRx, !rst && storeOk() && mIe);
    st = storeOk(); tx = txOk();
    @(posedge clk);
    if (rst) begin
      mReady = 0; mTrq = 0; mDn = 0; mOw = 0; mIe = 0; mType = 0;
    end else begin
      nDn    = st ? 1'b1 : (cpuFlagWr && cpuFlagClr[2]) ? 1'b0 : mDn;
      nOw    = (st && mDn) ? 1'b1 : (cpuFlagWr && cpuFlagClr[3]) ? 1'b0 : mOw;
      nTrq   = (cpuFlagWr && cpuFlagClr[1]) ? 1'b0 : (cpuFlagWr && cpuFlagSet[1]) ? 1'b1 :
               tx ? 1'b0 : mTrq;
      nReady = (cpuFlagWr && cpuFlagClr[0]) ? 1'b0 : (cpuFlagWr && cpuFlagSet[0]) ? 1'b1 : mReady;
      if (cpuCfgWr && !mReady) begin
        mType = int'(cpuCfgData[2:0]);
        mIe   = cpuCfgData[3];
      end
      mDn = nDn; mOw = nOw; mTrq = nTrq; mReady = nReady;
    end
    #1;
  endtask

  task automatic flagWrite(input logic [3:0] s, input logic [3:0] c);
    startCyc(); cpuFlagWr = 1; cpuFlagSet = s; cpuFlagClr = c; endCyc();
  endtask

  task automatic cfgWrite(input logic [3:0] d);
    startCyc(); cpuCfgWr = 1; cpuCfgData = d; endCyc();
  endtask

  task automatic idleCyc();
    startCyc(); endCyc();
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    idleCyc(); idleCyc();
    startCyc(); rst = 0; endCyc();
    // R1 reset state
    chk("R1", "ready", flagReady, 0);
    chk("R1", "dataNew", flagDataNew, 0);
    chk("R1", "permit", bufWrPermit, 1);
    chk("R1", "type", bufType, 0);

    // transmit buffer, interrupts enabled
    cfgWrite(4'b1000);
    flagWrite(4'b0011, 4'b0000);
    startCyc(); evTxDone = 1; #1;
    chk("R6", "irqTx pulse on tx done", irqTx, 1);
    endCyc();
    chk("R5", "txReq cleared", flagTxReq, 0);
    flagWrite(4'b0010, 4'b0000);
    // R5 collision: CPU set together with tx done
    startCyc(); evTxDone = 1; cpuFlagWr = 1; cpuFlagSet = 4'b0010; endCyc();
    chk("R5", "CPU set beats tx done", flagTxReq, 1);
    // R3 set and clear together: clear wins
    flagWrite(4'b0010, 4'b0010);
    chk("R3", "clear wins over set", flagTxReq, 0);

    // remote frames into type 0
    startCyc(); evRemoteStored = 1; #1;
    chk("R7", "irqRx on remote into type 0", irqRx, 1);
    endCyc();
    startCyc(); evRemoteStored = 1; endCyc();
    chk("R9", "overwrite on second store", flagOverwrite, 1);
    // R8/R9 collision: CPU clear loses to store
    startCyc(); evRemoteStored = 1; cpuFlagWr = 1; cpuFlagClr = 4'b1100; endCyc();
    chk("R8", "store beats CPU clear", flagDataNew, 1);
    chk("R9", "store beats CPU clear", flagOverwrite, 1);
    idleCyc();
    chk("R9", "overwrite sticky", flagOverwrite, 1);
    flagWrite(4'b0000, 4'b1100);
    // R4 CPU cannot set data-new or overwrite
    flagWrite(4'b1100, 4'b0000);
    chk("R4", "dataNew not settable", flagDataNew, 0);
    chk("R4", "overwrite not settable", flagOverwrite, 0);
    // R2 config frozen while ready
    cfgWrite(4'b0011);
    chk("R2", "config held while ready", bufType, 0);
    // R10 wrong type: data frame into type 0
    startCyc(); evDataStored = 1; #1;
    chk("R10", "no irq for data into type 0", irqRx, 0);
    endCyc();
    chk("R10", "no dataNew for data into type 0", flagDataNew, 0);
    // R10 not ready
    flagWrite(4'b0000, 4'b0001);
    startCyc(); evTxDone = 1; evRemoteStored = 1; #1;
    chk("R10", "no irq while not ready", irqTx | irqRx, 0);
    endCyc();
    chk("R10", "no dataNew while not ready", flagDataNew, 0);

    // receive buffer type 3, interrupts disabled
    cfgWrite(4'b0011);
    chk("R2", "config loaded when not ready", bufType, 3);
    flagWrite(4'b0001, 4'b0000);
    startCyc(); evDataStored = 1; #1;
    chk("R11", "no irq when disabled", irqRx, 0);
    endCyc();
    chk("R11", "dataNew still set", flagDataNew, 1);
    flagWrite(4'b0000, 4'b0101);
    cfgWrite(4'b1101);
    flagWrite(4'b0001, 4'b0100);
    startCyc(); evDataStored = 1; #1;
    chk("R7", "irqRx on data into type 5", irqRx, 1);
    endCyc();

    // random interleaving
    for (int n = 0; n < 3000; n++) begin
      startCyc();
      cpuCfgWr       = ($urandom % 8) == 0;
      cpuCfgData     = 4'($urandom);
      cpuFlagWr      = ($urandom % 4) == 0;
      cpuFlagSet     = 4'($urandom);
      cpuFlagClr     = 4'($urandom) & 4'($urandom);
      evTxDone       = ($urandom % 3) == 0;
      evDataStored   = ($urandom % 3) == 0;
      evRemoteStored = ($urandom % 3) == 0;
      endCyc();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule